// File: doc/BRIEF.md
# Edge-Detect Interrupt Controller

This block watches a vector of already-filtered digital input lines and raises an interrupt when a line that has detection enabled changes level. Every channel carries two mask bits, one arming it for low-to-high transitions and one for high-to-low transitions. On top of the per-channel masks, a control register holds global enables for each direction and separate enables for the two event sources that can drive the interrupt line.

Two sticky flags record events. The edge flag sets on the first qualifying transition, and the overflow flag sets when a further qualifying transition arrives while the edge flag is still set. Software acknowledges events by writing ones to a clear register. When the edge flag goes from clear to set, the block copies the whole input vector into a snapshot register, so the host can later see which lines moved. All of this state sits behind a byte-wide register port that has a one-cycle read latency.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After a synchronous reset, all rising and falling mask bits read 0, control (0x15) reads 0, status (0x14) reads 0 and `irq` is low.
- R2: Rising masks live at bytes 0x18, 0x19 and 0x1A, and falling masks at 0x20, 0x21 and 0x22. Byte k covers channels 8k to 8k+7, with the lowest channel in bit 0. Every mask byte reads back the value written to it.
- R3: A 0-to-1 change on a channel sets status bit 0 (edge) when that channel's rising mask bit and control bit 3 (rising enable) are both 1. The change counts at the first clock edge that samples the new input value.
- R4: A 1-to-0 change on a channel sets status bit 0 when that channel's falling mask bit and control bit 4 (falling enable) are both 1.
- R5: A transition on a channel whose mask bit for that direction is 0, or while the global enable for that direction is 0, leaves status unchanged.
- R6: A qualifying transition while status bit 0 is already 1 sets status bit 1 (overflow).
- R7: Writing 1 to bit 3 of the clear register (0x07) clears the edge flag, and writing 1 to bit 2 clears the overflow flag; one write may clear both. A qualifying transition in the same cycle as the clear leaves the edge flag set and does not set overflow.
- R8: Status bit 2 equals ((edge AND control bit 0) OR (overflow AND control bit 1)) AND control bit 2, and `irq` shows that bit one cycle later.
- R9: While control bit 2 is 0, including after control is written to 0, `irq` stays low.
- R10: Reading 0x06 returns 0x27.
- R11: Bytes 0x28, 0x29 and 0x2A hold a snapshot of the input vector, in the same byte layout as R2. The snapshot is captured when the edge flag goes from 0 to 1 and held unchanged while the flag stays set.
- R12: `rd_data` shows the addressed register on the cycle after `rd_en`. Control reads back its 5 bits with upper bits 0, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| in_vec | input | 24 | Filtered input lines |
| irq | output | 1 | Registered interrupt request |

## Verification
An input change driven before clock edge k sets the flags and the snapshot at edge k. It first shows up on `rd_data` one edge after a read strobe issued after k, and on `irq` at edge k+1. The bench therefore lets two edges pass after each input or control change before it checks `irq`. Every read pushes its expected byte into a queue at the moment the strobe is driven. A monitor pops that byte and compares it against `rd_data` half a cycle after the edge that registered the read, so each comparison lines up with exactly one strobe.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int unsigned ADR_ID     = 6'h06;
  localparam int unsigned ADR_CLR    = 6'h07;
  localparam int unsigned ADR_STAT   = 6'h14;
  localparam int unsigned ADR_CTRL   = 6'h15;
  localparam int unsigned ADR_RISE   = 6'h18;
  localparam int unsigned ADR_FALL   = 6'h20;
  localparam int unsigned ADR_SNAP   = 6'h28;
  localparam logic [7:0]  ID_VALUE   = 8'h27;
  localparam int unsigned CTRL_W     = 5;
  // control bit positions
  localparam int unsigned C_EDGE_EN  = 0;
  localparam int unsigned C_OVF_EN   = 1;
  localparam int unsigned C_IRQ_EN   = 2;
  localparam int unsigned C_RISE_EN  = 3;
  localparam int unsigned C_FALL_EN  = 4;
  // clear register bit positions
  localparam int unsigned K_OVF      = 2;
  localparam int unsigned K_EDGE     = 3;
endpackage

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
  import edge_irq_pkg::*;
#(
  parameter int NCH = 24,
  parameter int AW  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [7:0]        wdata,
  output logic [NCH-1:0]    rise_mask,
  output logic [NCH-1:0]    fall_mask,
  output logic [CTRL_W-1:0] ctrl,
  output logic              clr_edge,
  output logic              clr_ovf
);
  localparam int NB = NCH / 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_mask <= '0;
      fall_mask <= '0;
      ctrl      <= '0;
    end else if (wr_en) begin
      if (addr == AW'(ADR_CTRL)) ctrl <= wdata[CTRL_W-1:0];
      for (int b = 0; b < NB; b++) begin
        if (addr == AW'(ADR_RISE + b)) rise_mask[b*8 +: 8] <= wdata;
        if (addr == AW'(ADR_FALL + b)) fall_mask[b*8 +: 8] <= wdata;
      end
    end
  end

  assign clr_edge = wr_en && (addr == AW'(ADR_CLR)) && wdata[K_EDGE];
  assign clr_ovf  = wr_en && (addr == AW'(ADR_CLR)) && wdata[K_OVF];

  AST_MASK_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rise_mask == '0 && fall_mask == '0 && ctrl == '0)); // R1
endmodule

// File: rtl/edge_irq_detect.sv
module edge_irq_detect #(
  parameter int NCH = 24
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] in_vec,
  input  logic [NCH-1:0] rise_mask,
  input  logic [NCH-1:0] fall_mask,
  input  logic           rise_en,
  input  logic           fall_en,
  output logic           hit
);
  logic [NCH-1:0] in_q;
  logic [NCH-1:0] up_sel;
  logic [NCH-1:0] dn_sel;

  always_ff @(posedge clk) begin
    if (rst) in_q <= '0;
    else     in_q <= in_vec;
  end

  assign up_sel = in_vec & ~in_q & rise_mask;
  assign dn_sel = ~in_vec & in_q & fall_mask;
  assign hit    = (rise_en && (|up_sel)) || (fall_en && (|dn_sel));

  AST_NO_HIT_STILL: assert property (@(posedge clk) disable iff (rst)
    (in_vec == in_q) |-> !hit); // R5
endmodule

// File: rtl/edge_irq_status.sv
module edge_irq_status
  import edge_irq_pkg::*;
#(
  parameter int NCH = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              clr_edge,
  input  logic              clr_ovf,
  input  logic [NCH-1:0]    in_vec,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              edge_flag,
  output logic              ovf_flag,
  output logic              pending,
  output logic [NCH-1:0]    snap,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      edge_flag <= 1'b0;
      ovf_flag  <= 1'b0;
      snap      <= '0;
      irq       <= 1'b0;
    end else begin
      edge_flag <= hit | (edge_flag & ~clr_edge);
      ovf_flag  <= (hit & edge_flag & ~clr_edge) | (ovf_flag & ~clr_ovf);
      if (hit && !edge_flag) snap <= in_vec;
      irq       <= pending;
    end
  end

  assign pending = ((edge_flag & ctrl[C_EDGE_EN]) | (ovf_flag & ctrl[C_OVF_EN]))
                   & ctrl[C_IRQ_EN];

  AST_OVF_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> $past(edge_flag)); // R6
  AST_EDGE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (clr_edge && !hit) |=> !edge_flag); // R7
  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (rst)
    edge_flag |=> $stable(snap)); // R11
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !ctrl[C_IRQ_EN] |=> !irq); // R9
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int NCH = 24,
  parameter int AW  = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [7:0]     wdata,
  output logic [7:0]     rd_data,
  input  logic [NCH-1:0] in_vec,
  output logic           irq
);
  localparam int NB = NCH / 8;

  logic [NCH-1:0]    rise_mask, fall_mask, snap;
  logic [CTRL_W-1:0] ctrl;
  logic              clr_edge, clr_ovf, hit;
  logic              edge_flag, ovf_flag, pending;
  logic [7:0]        rd_mux;

  edge_irq_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rise_mask(rise_mask), .fall_mask(fall_mask), .ctrl(ctrl),
    .clr_edge(clr_edge), .clr_ovf(clr_ovf)
  );

  edge_irq_detect #(.NCH(NCH)) u_detect (
    .clk(clk), .rst(rst), .in_vec(in_vec),
    .rise_mask(rise_mask), .fall_mask(fall_mask),
    .rise_en(ctrl[C_RISE_EN]), .fall_en(ctrl[C_FALL_EN]), .hit(hit)
  );

  edge_irq_status #(.NCH(NCH)) u_status (
    .clk(clk), .rst(rst), .hit(hit), .clr_edge(clr_edge), .clr_ovf(clr_ovf),
    .in_vec(in_vec), .ctrl(ctrl), .edge_flag(edge_flag), .ovf_flag(ovf_flag),
    .pending(pending), .snap(snap), .irq(irq)
  );

  always_comb begin
    rd_mux = 8'h00;
    if (addr == AW'(ADR_ID))   rd_mux = ID_VALUE;
    if (addr == AW'(ADR_STAT)) rd_mux = {5'b0, pending, ovf_flag, edge_flag};
    if (addr == AW'(ADR_CTRL)) rd_mux = {{(8-CTRL_W){1'b0}}, ctrl};
    for (int b = 0; b < NB; b++) begin
      if (addr == AW'(ADR_RISE + b)) rd_mux = rise_mask[b*8 +: 8];
      if (addr == AW'(ADR_FALL + b)) rd_mux = fall_mask[b*8 +: 8];
      if (addr == AW'(ADR_SNAP + b)) rd_mux = snap[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= 8'h00;
    else if (rd_en) rd_data <= rd_mux;
  end

  AST_ID_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(ADR_ID)) |=> (rd_data == ID_VALUE)); // R10
endmodule

// File: tb/test_edge_irq_ctrl.sv
module test_edge_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rd_data;
  logic [23:0] in_vec = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sbq[$];

  always #10 clk = ~clk;

  edge_irq_ctrl i_edge_irq_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .in_vec(in_vec), .irq(irq)
  );

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sbq.push_back(it);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual %0b expected %0b", tag, irq, e);
    end
  endtask

  // monitor: compares rd_data half a cycle after the edge that registered a read
  initial begin
    forever begin
      logic fire;
      @(posedge clk);
      fire = rd_en;
      @(negedge clk);
      if (fire) begin
        item_t it;
        checks++;
        if (sbq.size() == 0) begin
          errors++;
          $display("FAIL R12 unexpected read actual %02h expected none", rd_data);
        end else begin
          it = sbq.pop_front();
          if (rd_data !== it.exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", it.tag, rd_data, it.exp);
          end
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(6'h18, 8'h00, "R1 rise mask");
    rd(6'h22, 8'h00, "R1 fall mask");
    rd(6'h15, 8'h00, "R1 control");
    rd(6'h14, 8'h00, "R1 status");
    // R10 identification, R12 unmapped
    rd(6'h06, 8'h27, "R10 id");
    rd(6'h3F, 8'h00, "R12 unmapped");
    // R2 mask programming and readback
    wr(6'h18, 8'h01); wr(6'h19, 8'hA5); wr(6'h1A, 8'h80);
    wr(6'h20, 8'h02); wr(6'h21, 8'h00); wr(6'h22, 8'h40);
    rd(6'h18, 8'h01, "R2 rise b0");
    rd(6'h19, 8'hA5, "R2 rise b1");
    rd(6'h1A, 8'h80, "R2 rise b2");
    rd(6'h20, 8'h02, "R2 fall b0");
    rd(6'h22, 8'h40, "R2 fall b2");
    // R5 masked channel rising, but global enables off
    in_vec = 24'h000001; settle();
    rd(6'h14, 8'h00, "R5 global enable off");
    chk_irq(1'b0, "R5");
    wr(6'h15, 8'h1F);
    rd(6'h15, 8'h1F, "R12 control readback");
    // R5 ch1 rising has no rise mask bit
    in_vec = 24'h000003; settle();
    rd(6'h14, 8'h00, "R5 unmasked channel");
    // R4 falling on ch1
    in_vec = 24'h000001; settle();
    chk_irq(1'b1, "R8 edge irq");
    rd(6'h14, 8'h05, "R4 falling edge");
    rd(6'h28, 8'h01, "R11 snapshot b0");
    // R6 overflow via rising ch8
    in_vec = 24'h000101; settle();
    rd(6'h14, 8'h07, "R6 overflow");
    rd(6'h29, 8'h00, "R11 snapshot held");
    // R7 clear both
    wr(6'h07, 8'h0C);
    rd(6'h14, 8'h00, "R7 clear both");
    chk_irq(1'b0, "R7 irq drops");
    // R3 rising ch23, snapshot recaptured
    in_vec = 24'h800101; settle();
    rd(6'h14, 8'h05, "R3 rising edge");
    rd(6'h2A, 8'h80, "R11 snapshot b2");
    rd(6'h29, 8'h01, "R11 snapshot b1");
    // R8 edge enable off
    wr(6'h15, 8'h1E); settle();
    rd(6'h14, 8'h01, "R8 edge enable off");
    chk_irq(1'b0, "R8 no pending");
    // R8 overflow source alone
    in_vec = 24'h800501; settle();
    rd(6'h14, 8'h07, "R8 overflow source");
    chk_irq(1'b1, "R8 ovf irq");
    // R9 irq enable off
    wr(6'h15, 8'h1A); settle();
    rd(6'h14, 8'h03, "R9 irq enable off");
    chk_irq(1'b0, "R9 gate");
    wr(6'h15, 8'h00); settle();
    chk_irq(1'b0, "R9 control zero");
    rd(6'h15, 8'h00, "R9 control readback");
    // R7 same-cycle clear and new edge
    wr(6'h15, 8'h1F);
    in_vec = 24'hC00501; settle();
    rd(6'h14, 8'h07, "R7 before clear");
    in_vec = 24'h800501;
    wr(6'h07, 8'h0C);
    settle();
    rd(6'h14, 8'h05, "R7 edge wins clear");
    rd(6'h2A, 8'h80, "R11 no recapture");
    settle();
    checks++;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL R12 pending reads actual %0d expected 0", sbq.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule